// File: doc/BRIEF.md
# Board Control Register Block

A small memory-mapped control and status peripheral for an evaluation board. It sits on a 32-bit register bus where every access completes in one cycle. The bus carries an address, a write strobe with write data, and a read strobe. The block holds two constant identification words: a build-date code and the processor clock rate in hertz. It also holds an LED register, which can be written and read back and which drives the LED pins directly. A DIP-switch word can be read; it comes from external switch inputs that are synchronized into the bus clock domain. Finally, there is a write-only trigger word. Writing one exact key value to it produces a single-cycle reset-request pulse; any other value is discarded.

Only the low 16 address bits are decoded, so the block answers across a 64 KiB window. Read data is registered and appears on the cycle after the read strobe. Every write is a full 32-bit word.

Top module: `brd_ctrl_regs`

## Requirements
- R1: A read at offset 0x0000 returns the build-date constant 0x09272011 (default of a parameter).
- R2: A read at offset 0x0004 returns the clock-rate constant 10000000 decimal (default of a parameter).
- R3: At offset 0x0008 sits the LED register. A write stores the full 32-bit word, and the `led_o` pins show it from the cycle after the write. A read returns the last value written.
- R4: A read at offset 0x000C returns the switch inputs after a two-flop synchronizer. A change on `sw_i` becomes visible in a read issued two clock edges after the change. Writes to 0x000C have no effect.
- R5: A write of exactly 0x0000DEAD to offset 0x0010 drives `rst_req_o` high for exactly one cycle: the cycle after the write. A write of any other value there leaves `rst_req_o` low. A read of 0x0010 returns zero.
- R6: Reset clears the LED register, the synchronized switch value, `rd_data_o` and `rst_req_o` to zero.
- R7: A read of any other offset returns zero, and a write to any other offset changes no register.
- R8: Only address bits 15:0 are decoded. Bits above bit 15 are ignored, and so are the low two bits (word access only).
- R9: Read data is registered. It is valid on the cycle after `rd_en_i` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 32 | Byte address; bits 15:0 are decoded |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| sw_i | input | 32 | Asynchronous DIP switch inputs |
| led_o | output | 32 | LED drive, 1 = on |
| rst_req_o | output | 1 | Single-cycle board reset request |

## Verification
On every cycle, the embedded assertions check four behaviours:
- the reset request is one cycle wide and follows only a key write;
- the LED pins track the last LED write;
- read data stays stable when there is no read;
- synchronized switch values lag the pins by two edges.

The bench's scenarios cover the rest:
- that the decode of each offset returns the right word;
- that high address bits are aliased away;
- that ignored writes leave every readable register untouched;
- that near-miss key values produce no pulse.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;
   localparam int unsigned DW = 32;
   localparam int unsigned OFFW = 16;
   typedef enum logic [2:0] {
      SEL_DATE  = 3'd0,
      SEL_CLK   = 3'd1,
      SEL_LED   = 3'd2,
      SEL_SW    = 3'd3,
      SEL_KICK  = 3'd4,
      SEL_NONE  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/brd_ctrl_decode.sv
module brd_ctrl_decode
   import brd_ctrl_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0] addr_i,
   output reg_sel_e      sel_o
);
   initial begin
      if (AW < OFFW) $error("address narrower than window");
   end

   logic [OFFW-1:0] off;
   assign off = addr_i[OFFW-1:0];

   always_comb begin
      unique case (off[OFFW-1:2])
         14'd0:   sel_o = SEL_DATE;
         14'd1:   sel_o = SEL_CLK;
         14'd2:   sel_o = SEL_LED;
         14'd3:   sel_o = SEL_SW;
         14'd4:   sel_o = SEL_KICK;
         default: sel_o = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/brd_ctrl_sync.sv
module brd_ctrl_sync #(
   parameter int unsigned W = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (STAGES < 2) $error("synchronizer needs two or more stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (!rst_ni) stg[g] <= '0;
         else if (g == 0) stg[g] <= d_i;
         else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
   end

   assign q_o = stg[STAGES-1];

   a_r4_sync_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni, 2) && $past(rst_ni) |-> q_o == $past(d_i, 2));
endmodule

// File: rtl/brd_ctrl_kick.sv
module brd_ctrl_kick #(
   parameter int unsigned DW = 32,
   parameter logic [DW-1:0] KEY = 32'h0000_DEAD
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          hit_i,
   input  logic [DW-1:0] data_i,
   output logic          pulse_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) pulse_o <= 1'b0;
      else pulse_o <= hit_i && (data_i == KEY);
   end

   a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o || $past(hit_i));
   a_r5_key_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pulse_o) |-> $past(hit_i) && $past(data_i) == KEY);
endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
   import brd_ctrl_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter logic [DW-1:0] DATE_CODE = 32'h0927_2011,
   parameter logic [DW-1:0] CLK_HZ = 32'd10_000_000,
   parameter logic [DW-1:0] KICK_KEY = 32'h0000_DEAD,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_en_i,
   output logic [DW-1:0] rd_data_o,
   input  logic [DW-1:0] sw_i,
   output logic [DW-1:0] led_o,
   output logic          rst_req_o
);
   reg_sel_e      sel;
   logic [DW-1:0] sw_sync;
   logic [DW-1:0] led_q;
   logic [DW-1:0] rd_mux;

   brd_ctrl_decode #(.AW(AW)) u_dec (.addr_i(addr_i), .sel_o(sel));

   brd_ctrl_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sw_i), .q_o(sw_sync));

   brd_ctrl_kick #(.DW(DW), .KEY(KICK_KEY)) u_kick (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .hit_i(wr_en_i && sel == SEL_KICK),
      .data_i(wr_data_i), .pulse_o(rst_req_o));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) led_q <= '0;
      else if (wr_en_i && sel == SEL_LED) led_q <= wr_data_i;
   end
   assign led_o = led_q;

   always_comb begin
      case (sel)
         SEL_DATE: rd_mux = DATE_CODE;
         SEL_CLK:  rd_mux = CLK_HZ;
         SEL_LED:  rd_mux = led_q;
         SEL_SW:   rd_mux = sw_sync;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_mux;
   end

   a_r3_led_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i[15:0] == 16'h0008 |=> led_o == $past(wr_data_i));
   a_r3_led_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(led_o));
   a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rd_data_o));
   a_r1_date_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && addr_i[15:2] == 14'd0 |=> rd_data_o == DATE_CODE);
endmodule

// File: tb/brd_ctrl_regs_tb_top.sv
module brd_ctrl_regs_tb_top;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] addr = 0, wdata = 0, sw = 0;
   logic        we = 0, re = 0;
   logic [31:0] rdata, led;
   logic        req;
   int checks = 0, errors = 0;
   logic [31:0] led_model = 0;
   int pulses = 0;

   always #10 clk = ~clk;

   brd_ctrl_regs dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
      .wr_data_i(wdata), .rd_en_i(re), .rd_data_o(rdata),
      .sw_i(sw), .led_o(led), .rst_req_o(req));

   always @(negedge clk) if (req) pulses++;

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] a, logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1;
      @(negedge clk); we = 0;
   endtask

   task automatic rd(logic [31:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; re = 1;
      @(negedge clk); re = 0; d = rdata;
   endtask

   function automatic logic [31:0] model_rd(logic [31:0] a, logic [31:0] swv);
      case (a[15:2])
         14'd0: return 32'h0927_2011;
         14'd1: return 32'd10_000_000;
         14'd2: return led_model;
         14'd3: return swv;
         default: return 32'h0;
      endcase
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      sw = 32'hA5A5_0F0F;
      repeat (3) @(negedge clk);
      chk("R6 led reset", led, 0);
      chk("R6 rdata reset", rdata, 0);
      chk("R6 req reset", {31'b0, req}, 0);
      rst_n = 1;
      @(negedge clk);
      rd(32'h0, v);           chk("R1 date", v, 32'h0927_2011);
      rd(32'h4, v);           chk("R2 clk", v, 32'd10_000_000);
      rd(32'hC, v);           chk("R4 sw", v, 32'hA5A5_0F0F);
      wr(32'h8, 32'h1234_5678); led_model = 32'h1234_5678;
      chk("R3 led pins", led, 32'h1234_5678);
      rd(32'h8, v);           chk("R3 led read", v, led_model);
      // R4 sync latency: change then read at second edge
      @(negedge clk); sw = 32'h0000_00FF; addr = 32'hC; re = 1;
      @(negedge clk); re = 0; chk("R4 after one edge old", rdata, 32'hA5A5_0F0F);
      @(negedge clk); addr = 32'hC; re = 1;
      @(negedge clk); re = 0; chk("R4 after two edges", rdata, 32'h0000_00FF);
      wr(32'hC, 32'hFFFF_FFFF); rd(32'hC, v); chk("R4 write ignored", v, 32'hFF);
      // R5 kick
      pulses = 0;
      @(negedge clk); addr = 32'h10; wdata = 32'hDEAD; we = 1;
      @(negedge clk); we = 0; chk("R5 pulse high", {31'b0, req}, 1);
      @(negedge clk); chk("R5 pulse low", {31'b0, req}, 0);
      chk("R5 one pulse", pulses, 1);
      pulses = 0;
      wr(32'h10, 32'h1000_DEAD); wr(32'h10, 32'hDEAE); wr(32'h10, 32'hDEAC);
      @(negedge clk); chk("R5 near-miss", pulses, 0);
      rd(32'h10, v); chk("R5 read zero", v, 0);
      // R7 unmapped
      wr(32'h14, 32'hCAFE_F00D); wr(32'hFFFC, 32'h1);
      chk("R7 led untouched", led, led_model);
      rd(32'h14, v); chk("R7 read zero", v, 0);
      rd(32'h8000, v); chk("R7 read high offset", v, 0);
      // R8 aliasing
      rd(32'hF002_0000, v); chk("R8 high bits date", v, 32'h0927_2011);
      rd(32'h0001_0006, v); chk("R8 low bits clk", v, 32'd10_000_000);
      wr(32'hABCD_0008, 32'h0BAD_BEEF); led_model = 32'h0BAD_BEEF;
      chk("R8 alias led write", led, led_model);
      // R9 hold
      rd(32'h0, v);
      @(negedge clk); addr = 32'h8;
      @(negedge clk); chk("R9 hold", rdata, 32'h0927_2011);
      // random phase
      pulses = 0;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, d;
         a = {$urandom} & 32'h0000_001C;
         if ($urandom_range(0, 3) == 0) a = a | ({$urandom} & 32'hFFFF_0000);
         d = $urandom;
         if (a[15:0] == 16'h10) d = 32'h1234;
         if ($urandom_range(0, 1) == 0) begin
            wr(a, d);
            if (a[15:0] == 16'h8) led_model = d;
            chk("R3 R7 random led", led, led_model);
         end else begin
            rd(a, v);
            chk("R7 R9 random read", v, model_rd(a, 32'hFF));
         end
      end
      chk("R5 random no pulse", pulses, 0);
      rst_n = 0; @(negedge clk); @(negedge clk);
      chk("R6 second reset led", led, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule